// File: doc/BRIEF.md
# GPIO Output Port Register Bank with Atomic Bit Updates

This block holds the output state of one general-purpose output port, 32 pins wide by default, and lets software change that state through a small register bus. Besides a plain read/write data register, it offers write-only registers that set, clear or invert selected pins. Each of these acts in a single bus access, so software never needs a read-modify-write sequence. Pins that software does not name in such a write keep their state.

Two registers work on 16 pins at a time. The combined register sets some pins and clears others in one write. The mask/value register drives the pins picked by a mask to the levels given in a value field. A configuration bit picks which half of the port these two registers reach. Every write lands in the output register on the clock edge that accepts it. The bus carries at most one access per cycle.

Top module: `gpio_out_bank`

## Requirements
- R1: While reset is asserted and after it, `pinOut` is all zeros and the half-select bit is 0, which selects the lower half, until the first write.
- R2: A write to offset 0 (data) replaces all pins with the write data on the next clock edge. A read of offset 0 returns the current `pinOut` in the same cycle.
- R3: A write to offset 1 (set) drives to 1 every pin whose write-data bit is 1. All other pins keep their state.
- R4: A write to offset 2 (clear) drives to 0 every pin whose write-data bit is 1. All other pins keep their state.
- R5: A write to offset 3 (toggle) inverts every pin whose write-data bit is 1. All other pins keep their state.
- R6: A write to offset 4 (combined) acts on the selected half only. Write-data bits [15:0] set pins of that half, and bits [31:16] clear the pins at the same position in that half. The other half is unchanged.
- R7: In a combined write, a pin whose set bit and clear bit are both 1 ends up at 1.
- R8: A write to offset 5 (mask/value) acts on the selected half only. Bits [31:16] are the mask and bits [15:0] the value. Each pin with mask bit 1 takes its value bit, and every other pin in either half keeps its state.
- R9: Bit 0 of offset 6 (config) selects the half used by offsets 4 and 5: 0 is pins [15:0] and 1 is pins [31:16]. The bit reads back at bit 0 of offset 6, and the other bits read 0.
- R10: Reads of offsets 1, 2, 3, 4, 5 and 7 return 0. A read never changes `pinOut`. A write to offset 7 has no effect.
- R11: In a cycle with no write (`busSel` low, or a read), `pinOut` holds its value on the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | An access is presented this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 3 | Register word offset |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the cycle of the read |
| pinOut | output | 32 | Port output state |

## Verification
The hardest states to reach from the ports are those where a 16-bit register acts on the upper half. They first need a config write, and a wrong half can only be told apart when both halves hold different, known patterns. The bench therefore loads a distinct pattern through the data register before each half-window test. It switches the half-select bit, checks the readback of that bit, and then drives combined and mask/value writes whose set bits and clear bits overlap. The result is compared against a model that places the 16-bit fields into the chosen half on its own.

// File: rtl/gpio_out_pkg.sv
`timescale 1ns/1ps
package gpio_out_pkg;

  localparam int ADDR_W = 3;

  // Register offsets; the numbering is the software-visible map
  typedef enum logic [ADDR_W-1:0] {
    REG_DATA    = 3'd0,
    REG_SET     = 3'd1,
    REG_CLR     = 3'd2,
    REG_TGL     = 3'd3,
    REG_PAIR    = 3'd4,
    REG_MASKVAL = 3'd5,
    REG_CFG     = 3'd6,
    REG_NONE    = 3'd7
  } regSelE;

  // One-hot strobes from the decoder to the datapath
  typedef struct packed {
    logic wrData;
    logic wrSet;
    logic wrClr;
    logic wrTgl;
    logic wrPair;
    logic wrMaskVal;
    logic wrCfg;
    logic rdData;
    logic rdCfg;
  } strobeT;

endpackage

// File: rtl/gpio_out_decode.sv
`timescale 1ns/1ps
module gpio_out_decode
  import gpio_out_pkg::*;
(
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output strobeT            strobe
);

  regSelE regSel;
  logic   doWrite;
  logic   doRead;

  assign regSel  = regSelE'(busAddr);
  assign doWrite = busSel & busWrite;
  assign doRead  = busSel & ~busWrite;

  always_comb begin
    strobe = '0;
    unique case (regSel)
      REG_DATA: begin
        strobe.wrData = doWrite;
        strobe.rdData = doRead;
      end
      REG_SET:     strobe.wrSet     = doWrite;
      REG_CLR:     strobe.wrClr     = doWrite;
      REG_TGL:     strobe.wrTgl     = doWrite;
      REG_PAIR:    strobe.wrPair    = doWrite;
      REG_MASKVAL: strobe.wrMaskVal = doWrite;
      REG_CFG: begin
        strobe.wrCfg = doWrite;
        strobe.rdCfg = doRead;
      end
      REG_NONE: ;
      default: ;
    endcase
  end

endmodule

// File: rtl/gpio_out_datapath.sv
`timescale 1ns/1ps
module gpio_out_datapath
  import gpio_out_pkg::*;
#(
  parameter int PORT_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strobe,
  input  logic [PORT_W-1:0] wdata,
  output logic [PORT_W-1:0] rdata,
  output logic [PORT_W-1:0] pinOut
);

  localparam int HALF_W  = PORT_W / 2;
  localparam int N_HALF  = 2;

  logic [PORT_W-1:0] dataQ;
  logic              upperSelQ;

  // Half-width fields of the write word
  logic [HALF_W-1:0] loField;
  logic [HALF_W-1:0] hiField;
  logic [HALF_W-1:0] setHalf;
  logic [HALF_W-1:0] clrHalf;

  assign loField = wdata[HALF_W-1:0];
  assign hiField = wdata[PORT_W-1:HALF_W];

  // Pair form: low field sets, high field clears.
  // Mask/value form: high field is the mask, low field the level.
  always_comb begin
    setHalf = '0;
    clrHalf = '0;
    if (strobe.wrPair) begin
      setHalf = loField;
      clrHalf = hiField;
    end else if (strobe.wrMaskVal) begin
      setHalf = hiField & loField;
      clrHalf = hiField & ~loField;
    end
  end

  // Place the half-width vectors into the selected window
  logic [PORT_W-1:0] setPlaced;
  logic [PORT_W-1:0] clrPlaced;

  for (genvar g = 0; g < N_HALF; g++) begin : gWindow
    localparam logic SEL_VAL = (g == 1);
    assign setPlaced[g*HALF_W +: HALF_W] = (upperSelQ == SEL_VAL) ? setHalf : '0;
    assign clrPlaced[g*HALF_W +: HALF_W] = (upperSelQ == SEL_VAL) ? clrHalf : '0;
  end

  // Full-width set / clear / invert vectors; set is applied after clear
  logic [PORT_W-1:0] setVec;
  logic [PORT_W-1:0] clrVec;
  logic [PORT_W-1:0] tglVec;
  logic              dataWe;
  logic [PORT_W-1:0] dataNext;

  always_comb begin
    setVec = setPlaced;
    clrVec = clrPlaced;
    tglVec = '0;
    if (strobe.wrData) begin
      setVec = wdata;
      clrVec = '1;
    end
    if (strobe.wrSet) setVec = wdata;
    if (strobe.wrClr) clrVec = wdata;
    if (strobe.wrTgl) tglVec = wdata;
  end

  assign dataWe   = strobe.wrData | strobe.wrSet | strobe.wrClr | strobe.wrTgl
                  | strobe.wrPair | strobe.wrMaskVal;
  assign dataNext = ((dataQ & ~clrVec) | setVec) ^ tglVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataQ <= '0;
    end else if (dataWe) begin
      dataQ <= dataNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      upperSelQ <= 1'b0;
    end else if (strobe.wrCfg) begin
      upperSelQ <= wdata[0];
    end
  end

  // Readback: only data and config return content
  always_comb begin
    rdata = '0;
    if (strobe.rdData) begin
      rdata = dataQ;
    end else if (strobe.rdCfg) begin
      rdata[0] = upperSelQ;
    end
  end

  assign pinOut = dataQ;

endmodule

// File: rtl/gpio_out_bank.sv
`timescale 1ns/1ps
module gpio_out_bank
  import gpio_out_pkg::*;
#(
  parameter int PORT_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [PORT_W-1:0] busWdata,
  output logic [PORT_W-1:0] busRdata,
  output logic [PORT_W-1:0] pinOut
);

  strobeT strobe;

  gpio_out_decode uDecode (
    .busSel   (busSel),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .strobe   (strobe)
  );

  gpio_out_datapath #(.PORT_W(PORT_W)) uPath (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .wdata  (busWdata),
    .rdata  (busRdata),
    .pinOut (pinOut)
  );

endmodule

// File: rtl/gpio_out_bank_chk.sv
`timescale 1ns/1ps
module gpio_out_bank_chk #(
  parameter int PORT_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              busSel,
  input logic              busWrite,
  input logic [2:0]        busAddr,
  input logic [PORT_W-1:0] busWdata,
  input logic [PORT_W-1:0] busRdata,
  input logic [PORT_W-1:0] pinOut
);

  logic wrAcc;
  logic rdAcc;
  assign wrAcc = busSel & busWrite;
  assign rdAcc = busSel & ~busWrite;

  // R2
  data_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrAcc && busAddr == 3'd0) |=> pinOut == $past(busWdata));

  // R2
  data_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdAcc && busAddr == 3'd0) |-> busRdata == pinOut);

  // R3
  set_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrAcc && busAddr == 3'd1) |=> pinOut == ($past(pinOut) | $past(busWdata)));

  // R4
  clear_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrAcc && busAddr == 3'd2) |=> pinOut == ($past(pinOut) & ~$past(busWdata)));

  // R5
  toggle_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrAcc && busAddr == 3'd3) |=> pinOut == ($past(pinOut) ^ $past(busWdata)));

  // R10
  wo_read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdAcc && busAddr != 3'd0 && busAddr != 3'd6) |-> busRdata == '0);

  // R10
  unused_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrAcc && busAddr == 3'd7) |=> $stable(pinOut));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrAcc |=> $stable(pinOut));

  // R9
  cfg_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdAcc && busAddr == 3'd6) |-> busRdata[PORT_W-1:1] == '0);

  // R1
  reset_zero_chk: assert property (@(posedge clk)
    !rstN |-> pinOut == '0);

endmodule

bind gpio_out_bank gpio_out_bank_chk #(.PORT_W(PORT_W)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .busSel   (busSel),
  .busWrite (busWrite),
  .busAddr  (busAddr),
  .busWdata (busWdata),
  .busRdata (busRdata),
  .pinOut   (pinOut)
);

// File: tb/sim_gpio_out_bank.sv
`timescale 1ns/1ps
module sim_gpio_out_bank;

  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         busSel = 1'b0;
  logic         busWrite = 1'b0;
  logic [2:0]   busAddr = '0;
  logic [W-1:0] busWdata = '0;
  logic [W-1:0] busRdata;
  logic [W-1:0] pinOut;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  logic [W-1:0] expPins = '0;
  bit           expUpper = 1'b0;

  always #2.5 clk = ~clk;

  gpio_out_bank #(.PORT_W(W)) u0 (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .pinOut(pinOut)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic busWr(input logic [2:0] a, input logic [W-1:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0; busWdata = '0;
  endtask

  task automatic busRd(input logic [2:0] a, output logic [W-1:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b0; busAddr = a;
    #1 d = busRdata;
    @(negedge clk);
    busSel = 1'b0;
  endtask

  // Independent model of the 16-bit forms
  function automatic logic [W-1:0] place(input logic [15:0] h, input bit upper);
    return upper ? {h, 16'h0} : {16'h0, h};
  endfunction

  function automatic logic [W-1:0] modelPair(input logic [W-1:0] cur, input logic [W-1:0] d, input bit upper);
    logic [W-1:0] s, c;
    s = place(d[15:0], upper);
    c = place(d[31:16], upper);
    return (cur & ~c) | s;
  endfunction

  function automatic logic [W-1:0] modelMaskVal(input logic [W-1:0] cur, input logic [W-1:0] d, input bit upper);
    logic [W-1:0] m, v;
    m = place(d[31:16], upper);
    v = place(d[15:0], upper);
    return (cur & ~m) | (v & m);
  endfunction

  task automatic tReset();
    logic [W-1:0] r;
    check("R1 pins during reset", pinOut, '0);
    @(negedge clk); rstN = 1'b1;
    check("R1 pins after reset", pinOut, '0);
    busRd(3'd6, r);
    check("R1 half select after reset", r, '0);
  endtask

  task automatic tDataRw();
    logic [W-1:0] r;
    busWr(3'd0, 32'hA5A5_0F0F); expPins = 32'hA5A5_0F0F;
    check("R2 data write", pinOut, expPins);
    busRd(3'd0, r);
    check("R2 data read", r, expPins);
    busWr(3'd0, 32'h1234_5678); expPins = 32'h1234_5678;
    check("R2 data overwrite", pinOut, expPins);
  endtask

  task automatic tSetClrTgl();
    busWr(3'd1, 32'h0000_F0F0); expPins = expPins | 32'h0000_F0F0;
    check("R3 set", pinOut, expPins);
    busWr(3'd2, 32'hA000_0005 | 32'h0000_0070); expPins = expPins & ~(32'hA000_0075);
    check("R4 clear", pinOut, expPins);
    busWr(3'd3, 32'hFFFF_0000); expPins = expPins ^ 32'hFFFF_0000;
    check("R5 toggle", pinOut, expPins);
    busWr(3'd1, 32'h0); 
    check("R3 set with zero word", pinOut, expPins);
  endtask

  task automatic tPairLower();
    busWr(3'd0, 32'hCAFE_3C3C); expPins = 32'hCAFE_3C3C;
    busWr(3'd4, 32'h00FF_0F00); expPins = modelPair(expPins, 32'h00FF_0F00, 1'b0);
    check("R6 pair lower", pinOut, expPins);
    busWr(3'd4, 32'h0003_0001); expPins = modelPair(expPins, 32'h0003_0001, 1'b0);
    check("R7 set wins lower", pinOut, expPins);
    check("R7 bit0 high", {31'h0, pinOut[0]}, 32'h1);
  endtask

  task automatic tPairUpper();
    logic [W-1:0] r;
    busWr(3'd6, 32'h0000_0001); expUpper = 1'b1;
    busRd(3'd6, r);
    check("R9 half select readback", r, 32'h1);
    busWr(3'd0, 32'h5A5A_C3C3); expPins = 32'h5A5A_C3C3;
    busWr(3'd4, 32'hF0F0_0F0F); expPins = modelPair(expPins, 32'hF0F0_0F0F, 1'b1);
    check("R6 pair upper", pinOut, expPins);
    busWr(3'd4, 32'h8001_8000); expPins = modelPair(expPins, 32'h8001_8000, 1'b1);
    check("R7 set wins upper", pinOut, expPins);
  endtask

  task automatic tMaskVal();
    busWr(3'd0, 32'h0F0F_F0F0); expPins = 32'h0F0F_F0F0;
    busWr(3'd5, 32'hF00F_1234); expPins = modelMaskVal(expPins, 32'hF00F_1234, expUpper);
    check("R8 mask/value upper", pinOut, expPins);
    busWr(3'd6, 32'hFFFF_FFFE); expUpper = 1'b0;
    busWr(3'd5, 32'h00FF_AA55); expPins = modelMaskVal(expPins, 32'h00FF_AA55, expUpper);
    check("R8 mask/value lower", pinOut, expPins);
    busWr(3'd5, 32'h0000_FFFF);
    check("R8 zero mask", pinOut, expPins);
  endtask

  task automatic tReadZero();
    logic [W-1:0] r;
    foreach (r[i]) if (i < 1) ;
    for (int a = 1; a < 8; a++) begin
      if (a != 6) begin
        busRd(3'(a), r);
        check($sformatf("R10 read offset %0d", a), r, '0);
      end
    end
    check("R10 reads leave pins", pinOut, expPins);
    busWr(3'd7, 32'hFFFF_FFFF);
    check("R10 write offset 7 ignored", pinOut, expPins);
    busRd(3'd6, r);
    check("R10 offset 7 leaves half select", r, '0);
  endtask

  task automatic tIdle();
    repeat (4) @(negedge clk);
    check("R11 idle hold", pinOut, expPins);
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b1; busAddr = 3'd0; busWdata = 32'hDEAD_BEEF;
    @(negedge clk);
    busWrite = 1'b0; busWdata = '0;
    check("R11 unselected write ignored", pinOut, expPins);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tReset();
    tDataRw();
    tSetClrTgl();
    tPairLower();
    tPairUpper();
    tMaskVal();
    tReadZero();
    tIdle();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule